// File: doc/BRIEF.md
# UART Line Status Register

This block produces the eight-bit line status byte of a 16450/16550-compatible serial port, together with the transmit-holding-empty interrupt request. It watches receiver events (one strobe per completed character with its parity and framing flags), the raw receive line and a bit-time tick for break detection, the host's read strobes for the status byte and the receive buffer, the host's transmit write strobe, the transmit FIFO occupancy and a transmit-shifter busy flag.

Receive occupancy is tracked by a small tag FIFO that runs in step with the external data FIFO. Each entry holds three error tags (parity, framing, break), so that in FIFO mode a character's errors reach the status byte only when that character becomes the head of the buffer. In non-FIFO mode the same structure acts as a one-deep holding register. The status byte is combinational from registered state, so a host read returns the flags as they stand before the read clears them.

Top module: `uart_line_status`

## Requirements
- R1: After reset the status byte reads 0x60 with an idle transmitter: bit 0 data ready, bit 1 overrun, bit 2 parity error, bit 3 framing error, bit 4 break, bit 5 holding empty, bit 6 transmitter empty, bit 7 FIFO error summary.
- R2: In non-FIFO mode (fifo_mode=0) bit 0 is 1 while a character is held and returns to 0 after rx_rd.
- R3: In FIFO mode bit 0 is 1 when the receive count is at or above the trigger level; trig_sel 0,1,2,3 selects 1, 4, 8 and RX_DEPTH-2 (14) characters.
- R4: A character strobe arriving when the buffer is full (1 entry in non-FIFO mode, RX_DEPTH in FIFO mode) and no read frees space is discarded and sets bit 1; the discarded character's flags never appear.
- R5: rx_pe and rx_fe are stored with their character; bits 2 and 3 set when that character becomes the head of the buffer and stay set until an LSR read.
- R6: With rx_line low, the tick that takes the run of space ticks beyond 2*(start+data+parity+stop)+3 (data = 5+word_len) raises a break event, once per run; the next accepted character carries the break tag, and bit 4 sets when it reaches the head.
- R7: Bit 7 is always 0 in non-FIFO mode; in FIFO mode it is 1 while any buffered character carries a tag, and after such characters have left it stays 1 until an LSR read.
- R8: lsr_rd clears bits 1 to 4 and the bit 7 memory at the clock edge ending the read cycle; the value read is the pre-clear value, and a flag-setting event in the same cycle leaves its flag set.
- R9: Bit 5 clears in the cycle after thr_wr and sets in the cycle after tx_level is 0 with no write; thre_irq equals bit 5 AND thre_ie.
- R10: Bit 6 is 1 only when bit 5 is 1, tx_level is 0 and tx_busy is 0.
- R11: A return of rx_line to 1 restarts the break run count, so two space runs each shorter than the limit raise no break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 selects FIFO mode, 0 single-character mode |
| trig_sel | input | 2 | Receive trigger level select |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present in the frame |
| rx_line | input | 1 | Receive line level, 1 = mark |
| bit_tick | input | 1 | One pulse per bit time |
| rx_push | input | 1 | A complete character was received |
| rx_pe | input | 1 | Parity error of the pushed character |
| rx_fe | input | 1 | Framing error of the pushed character |
| rx_rd | input | 1 | Host reads the receive buffer |
| lsr_rd | input | 1 | Host reads the status byte |
| thr_wr | input | 1 | Host writes the transmit buffer |
| tx_level | input | 5 | Transmit FIFO occupancy |
| tx_busy | input | 1 | Transmit shifter holds a character |
| thre_ie | input | 1 | Holding-empty interrupt enable |
| lsr | output | 8 | Line status byte |
| thre_irq | output | 1 | Holding-empty interrupt request |

## Verification
Every status bit except bit 6 is due one clock edge after the stimulus that changes it: an accepted character, a read, a write or a break tick alters registered state, and the byte reflects it in the next cycle. Bit 6 and the pre-clear value of a read are combinational and are due in the same cycle as their inputs. The bench drives inputs just after the falling edge and compares the byte half a nanosecond later against a cycle-based model that advances once per rising edge, so each comparison sees the state left by the previous edge plus the current inputs.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
package lsr_pkg;

  localparam int unsigned BRK_W = 6;

  localparam int unsigned B_DR   = 0;
  localparam int unsigned B_OE   = 1;
  localparam int unsigned B_PE   = 2;
  localparam int unsigned B_FE   = 3;
  localparam int unsigned B_BI   = 4;
  localparam int unsigned B_THRE = 5;
  localparam int unsigned B_TEMT = 6;
  localparam int unsigned B_FERR = 7;

  typedef struct packed {
    logic bi;
    logic fe;
    logic pe;
  } rx_tag_t;

  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    int unsigned lvl;
    case (sel)
      2'd0:    lvl = 1;
      2'd1:    lvl = 4;
      2'd2:    lvl = 8;
      default: lvl = depth - 2;
    endcase
    return lvl;
  endfunction

  // start + data + parity + stop, doubled, plus three bit times
  function automatic logic [BRK_W-1:0] break_limit(input logic [1:0] wlen, input logic par);
    int unsigned frame;
    frame = 1 + (5 + int'(wlen)) + int'(par) + 1;
    return BRK_W'(2 * frame + 3);
  endfunction

endpackage

// File: rtl/lsr_rst_sync.sv
`timescale 1ns/1ps
module lsr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/lsr_break_det.sv
`timescale 1ns/1ps
module lsr_break_det #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic             bit_tick,
  input  logic [CNT_W-1:0] limit,
  input  logic             consume,
  output logic             brk_evt,
  output logic             brk_tag
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fired_q, fired_d;
  logic             pend_q, pend_d;

  assign brk_evt = ~rx_line & bit_tick & ~fired_q & (cnt_q >= limit);
  assign brk_tag = pend_q | brk_evt;

  always_comb begin
    cnt_d   = cnt_q;
    fired_d = fired_q;
    if (rx_line) begin
      cnt_d   = '0;
      fired_d = 1'b0;
    end else if (bit_tick && !fired_q) begin
      if (brk_evt) fired_d = 1'b1;
      else         cnt_d   = cnt_q + CNT_W'(1);
    end
    pend_d = consume ? 1'b0 : brk_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
      pend_q  <= pend_d;
    end
  end

  // R6
  brk_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> !brk_evt);

  // R11
  mark_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_line |=> !brk_evt);

endmodule

// File: rtl/lsr_err_fifo.sv
`timescale 1ns/1ps
module lsr_err_fifo
  import lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          push,
  input  rx_tag_t       push_tag,
  input  logic          rd,
  output logic [CW-1:0] count,
  output logic          push_acc,
  output logic          ovr_evt,
  output logic          head_load,
  output rx_tag_t       head_tag,
  output logic          err_any
);
  localparam int unsigned AW = $clog2(DEPTH);

  rx_tag_t       mem [DEPTH];
  logic [AW-1:0] rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CW-1:0] count_q, count_d, err_q, err_d, cap_lim;
  logic          pop_acc, full, head_from_push;

  assign cap_lim  = fifo_mode ? CW'(DEPTH) : CW'(1);
  assign full     = count_q >= cap_lim;
  assign pop_acc  = rd & (count_q != '0);
  assign push_acc = push & (~full | pop_acc);
  assign ovr_evt  = push & ~push_acc;

  assign head_from_push = (count_q == '0) | (pop_acc & (count_q == CW'(1)));
  assign head_load = (push_acc & head_from_push) | (pop_acc & (count_q >= CW'(2)));
  assign head_tag  = head_from_push ? push_tag : mem[rd_ptr_q + AW'(1)];

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    count_d  = count_q;
    err_d    = err_q;
    if (pop_acc) begin
      rd_ptr_d = rd_ptr_q + AW'(1);
      count_d  = count_d - CW'(1);
      if (|mem[rd_ptr_q]) err_d = err_d - CW'(1);
    end
    if (push_acc) begin
      wr_ptr_d = wr_ptr_q + AW'(1);
      count_d  = count_d + CW'(1);
      if (|push_tag) err_d = err_d + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
      err_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      count_q  <= count_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr_q] <= push_tag;
  end

  assign count   = count_q;
  assign err_any = err_q != '0;

  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  // R2
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_acc && !push_acc) |=> (count_q == $past(count_q) - CW'(1)));

endmodule

// File: rtl/lsr_status_reg.sv
`timescale 1ns/1ps
module lsr_status_reg
  import lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH) + 1,
  parameter int unsigned TX_CW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic [1:0]       trig_sel,
  input  logic [CW-1:0]    rx_count,
  input  logic             head_load,
  input  rx_tag_t          head_tag,
  input  logic             err_any,
  input  logic             ovr_evt,
  input  logic             lsr_rd,
  input  logic             thr_wr,
  input  logic [TX_CW-1:0] tx_level,
  input  logic             tx_busy,
  input  logic             thre_ie,
  output logic [7:0]       lsr_o,
  output logic             thre_irq_o
);
  logic          pe_q, pe_d, fe_q, fe_d, bi_q, bi_d, oe_q, oe_d;
  logic          hold_q, hold_d, thre_q, thre_d;
  logic [CW-1:0] trig;
  logic          dr, temt, tx_empty;

  assign tx_empty = tx_level == '0;

  always_comb begin
    pe_d   = (head_load & head_tag.pe) | (pe_q & ~lsr_rd);
    fe_d   = (head_load & head_tag.fe) | (fe_q & ~lsr_rd);
    bi_d   = (head_load & head_tag.bi) | (bi_q & ~lsr_rd);
    oe_d   = ovr_evt | (oe_q & ~lsr_rd);
    hold_d = ~lsr_rd & (hold_q | err_any);
    if (thr_wr)        thre_d = 1'b0;
    else if (tx_empty) thre_d = 1'b1;
    else               thre_d = thre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      bi_q   <= 1'b0;
      oe_q   <= 1'b0;
      hold_q <= 1'b0;
      thre_q <= 1'b1;
    end else begin
      pe_q   <= pe_d;
      fe_q   <= fe_d;
      bi_q   <= bi_d;
      oe_q   <= oe_d;
      hold_q <= hold_d;
      thre_q <= thre_d;
    end
  end

  assign trig = CW'(trig_level(trig_sel, DEPTH));
  assign dr   = fifo_mode ? (rx_count >= trig) : (rx_count != '0);
  assign temt = thre_q & tx_empty & ~tx_busy;

  always_comb begin
    lsr_o         = '0;
    lsr_o[B_DR]   = dr;
    lsr_o[B_OE]   = oe_q;
    lsr_o[B_PE]   = pe_q;
    lsr_o[B_FE]   = fe_q;
    lsr_o[B_BI]   = bi_q;
    lsr_o[B_THRE] = thre_q;
    lsr_o[B_TEMT] = temt;
    lsr_o[B_FERR] = fifo_mode & (err_any | hold_q);
  end

  assign thre_irq_o = thre_q & thre_ie;

  // R5
  pe_on_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_load && head_tag.pe) |=> lsr_o[B_PE]);

  // R4
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |-> (rx_count != '0));

  // R8
  oe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ovr_evt) |=> !lsr_o[B_OE]);

  // R9
  thre_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !lsr_o[B_THRE]);

endmodule

// File: rtl/uart_line_status.sv
`timescale 1ns/1ps
module uart_line_status
  import lsr_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 16,
  parameter int unsigned TX_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fifo_mode,
  input  logic [1:0]                   trig_sel,
  input  logic [1:0]                   word_len,
  input  logic                         parity_en,
  input  logic                         rx_line,
  input  logic                         bit_tick,
  input  logic                         rx_push,
  input  logic                         rx_pe,
  input  logic                         rx_fe,
  input  logic                         rx_rd,
  input  logic                         lsr_rd,
  input  logic                         thr_wr,
  input  logic [$clog2(TX_DEPTH):0]    tx_level,
  input  logic                         tx_busy,
  input  logic                         thre_ie,
  output logic [7:0]                   lsr,
  output logic                         thre_irq
);
  localparam int unsigned RX_CW = $clog2(RX_DEPTH) + 1;
  localparam int unsigned TX_CW = $clog2(TX_DEPTH) + 1;

  logic             rst_i_n;
  logic [BRK_W-1:0] brk_lim;
  logic             brk_evt, brk_tag;
  logic             push_acc, ovr_evt, head_load, err_any;
  logic [RX_CW-1:0] rx_count;
  rx_tag_t          push_tag, head_tag;

  lsr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign brk_lim = break_limit(word_len, parity_en);

  lsr_break_det #(.CNT_W(BRK_W)) u_brk (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .rx_line  (rx_line),
    .bit_tick (bit_tick),
    .limit    (brk_lim),
    .consume  (push_acc),
    .brk_evt  (brk_evt),
    .brk_tag  (brk_tag)
  );

  assign push_tag = '{bi: brk_tag, fe: rx_fe, pe: rx_pe};

  lsr_err_fifo #(.DEPTH(RX_DEPTH), .CW(RX_CW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .fifo_mode (fifo_mode),
    .push      (rx_push),
    .push_tag  (push_tag),
    .rd        (rx_rd),
    .count     (rx_count),
    .push_acc  (push_acc),
    .ovr_evt   (ovr_evt),
    .head_load (head_load),
    .head_tag  (head_tag),
    .err_any   (err_any)
  );

  lsr_status_reg #(.DEPTH(RX_DEPTH), .CW(RX_CW), .TX_CW(TX_CW)) u_stat (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .fifo_mode  (fifo_mode),
    .trig_sel   (trig_sel),
    .rx_count   (rx_count),
    .head_load  (head_load),
    .head_tag   (head_tag),
    .err_any    (err_any),
    .ovr_evt    (ovr_evt),
    .lsr_rd     (lsr_rd),
    .thr_wr     (thr_wr),
    .tx_level   (tx_level),
    .tx_busy    (tx_busy),
    .thre_ie    (thre_ie),
    .lsr_o      (lsr),
    .thre_irq_o (thre_irq)
  );

  // R6
  brk_tag_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (brk_evt && !push_acc) |=> brk_tag);

endmodule

// File: tb/test_uart_line_status.sv
`timescale 1ns/100ps
module test_uart_line_status;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_mode, parity_en, rx_line, bit_tick, rx_push, rx_pe, rx_fe;
  logic       rx_rd, lsr_rd, thr_wr, tx_busy, thre_ie;
  logic [1:0] trig_sel, word_len;
  logic [4:0] tx_level;
  logic [7:0] lsr;
  logic       thre_irq;

  int checks = 0;
  int errors = 0;

  int         mcnt, mbcnt;
  logic [2:0] mq [16];
  bit         mpe, mfe, mbi, moe, mhold, mthre, mfired, mpend;

  always #2 clk = ~clk;

  uart_line_status i_uart_line_status (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .trig_sel(trig_sel),
    .word_len(word_len), .parity_en(parity_en), .rx_line(rx_line),
    .bit_tick(bit_tick), .rx_push(rx_push), .rx_pe(rx_pe), .rx_fe(rx_fe),
    .rx_rd(rx_rd), .lsr_rd(lsr_rd), .thr_wr(thr_wr), .tx_level(tx_level),
    .tx_busy(tx_busy), .thre_ie(thre_ie), .lsr(lsr), .thre_irq(thre_irq)
  );

  function automatic string req_of(input int b);
    case (b)
      0: return fifo_mode ? "R3" : "R2";
      1: return "R4";
      2: return "R5";
      3: return "R5";
      4: return "R6";
      5: return "R9";
      6: return "R10";
      default: return "R7";
    endcase
  endfunction

  function automatic bit m_errany();
    bit e = 0;
    for (int i = 0; i < 16; i++) if (i < mcnt && mq[i] != 3'b000) e = 1;
    return e;
  endfunction

  function automatic logic [7:0] exp_lsr();
    int trig;
    logic [7:0] e;
    case (trig_sel)
      2'd0: trig = 1;
      2'd1: trig = 4;
      2'd2: trig = 8;
      default: trig = 14;
    endcase
    e[0] = fifo_mode ? (mcnt >= trig) : (mcnt != 0);
    e[1] = moe;
    e[2] = mpe;
    e[3] = mfe;
    e[4] = mbi;
    e[5] = mthre;
    e[6] = mthre && tx_level == 0 && !tx_busy;
    e[7] = fifo_mode && (m_errany() || mhold);
    return e;
  endfunction

  task automatic model_reset();
    mcnt = 0; mbcnt = 0;
    for (int i = 0; i < 16; i++) mq[i] = 3'b000;
    mpe = 0; mfe = 0; mbi = 0; moe = 0; mhold = 0; mthre = 1; mfired = 0; mpend = 0;
  endtask

  task automatic idle();
    rx_push = 0; rx_pe = 0; rx_fe = 0; rx_rd = 0; lsr_rd = 0; thr_wr = 0; bit_tick = 0;
  endtask

  task automatic expect_now(input string req, input logic [7:0] mask, input logic [7:0] val);
    #0.2;
    checks++;
    if ((lsr & mask) !== val) begin
      errors++;
      $display("FAIL %s: lsr&%02h actual %02h expected %02h", req, mask, lsr & mask, val);
    end
  endtask

  task automatic cyc();
    logic [7:0] e;
    int cap, lim;
    bit pop, push, ovr, evt, hl, ea;
    logic [2:0] ptag, ht;
    #0.5;
    e = exp_lsr();
    checks++;
    if (lsr !== e) begin
      errors++;
      for (int b = 0; b < 8; b++)
        if (lsr[b] !== e[b]) begin
          $display("FAIL %s: lsr actual %02h expected %02h (bit %0d)", req_of(b), lsr, e, b);
          break;
        end
    end
    checks++;
    if (thre_irq !== (mthre & thre_ie)) begin
      errors++;
      $display("FAIL R9: thre_irq actual %0b expected %0b", thre_irq, mthre & thre_ie);
    end
    // model advance for the coming rising edge
    cap  = fifo_mode ? 16 : 1;
    lim  = 2 * (1 + 5 + int'(word_len) + int'(parity_en) + 1) + 3;
    pop  = rx_rd && mcnt > 0;
    push = rx_push && (mcnt < cap || pop);
    ovr  = rx_push && !push;
    evt  = !rx_line && bit_tick && !mfired && (mbcnt >= lim);
    ptag = {mpend | evt, rx_fe, rx_pe};
    hl = 0; ht = 3'b000;
    if (pop && mcnt >= 2) begin hl = 1; ht = mq[1]; end
    else if (push && (mcnt == 0 || (pop && mcnt == 1))) begin hl = 1; ht = ptag; end
    ea = m_errany();
    mpe   = (hl & ht[0]) | (mpe & !lsr_rd);
    mfe   = (hl & ht[1]) | (mfe & !lsr_rd);
    mbi   = (hl & ht[2]) | (mbi & !lsr_rd);
    moe   = ovr | (moe & !lsr_rd);
    mhold = !lsr_rd && (mhold || ea);
    if (thr_wr) mthre = 0;
    else if (tx_level == 0) mthre = 1;
    if (pop) begin
      for (int i = 0; i < 15; i++) mq[i] = mq[i+1];
      mcnt--;
    end
    if (push) begin
      mq[mcnt] = ptag;
      mcnt++;
    end
    if (rx_line) begin mbcnt = 0; mfired = 0; end
    else if (bit_tick && !mfired) begin
      if (evt) mfired = 1;
      else mbcnt++;
    end
    mpend = push ? 0 : (mpend | evt);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; idle();
    fifo_mode = 0; trig_sel = 0; word_len = 2'd3; parity_en = 0; rx_line = 1;
    tx_level = 0; tx_busy = 0; thre_ie = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset value
    expect_now("R1", 8'hFF, 8'h60);
    cyc();
    thre_ie = 1;
    cyc();

    // R2 / R4 single-character mode
    rx_push = 1; cyc(); idle();
    expect_now("R2", 8'h01, 8'h01);
    rx_push = 1; rx_pe = 1; cyc(); idle();
    expect_now("R4", 8'h06, 8'h02);
    lsr_rd = 1;
    expect_now("R8", 8'h02, 8'h02);
    cyc(); idle();
    expect_now("R4", 8'h02, 8'h00);
    rx_rd = 1; cyc(); idle();
    expect_now("R2", 8'h01, 8'h00);

    // R3 trigger levels
    fifo_mode = 1; trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) begin rx_push = 1; cyc(); end
    idle();
    expect_now("R3", 8'h01, 8'h00);
    rx_push = 1; cyc(); idle();
    expect_now("R3", 8'h01, 8'h01);
    trig_sel = 2'd3;
    expect_now("R3", 8'h01, 8'h00);
    for (int i = 0; i < 10; i++) begin rx_push = 1; cyc(); end
    idle();
    expect_now("R3", 8'h01, 8'h01);
    for (int i = 0; i < 2; i++) begin rx_push = 1; cyc(); end
    idle();
    expect_now("R4", 8'h02, 8'h00);
    rx_push = 1; rx_fe = 1; cyc(); idle();
    expect_now("R4", 8'h0A, 8'h02);
    lsr_rd = 1; cyc(); idle();
    for (int i = 0; i < 16; i++) begin rx_rd = 1; cyc(); end
    idle(); trig_sel = 2'd0;
    expect_now("R3", 8'h01, 8'h00);

    // R5 / R7 per-character tags
    rx_push = 1; cyc(); rx_pe = 1; cyc(); idle();
    expect_now("R7", 8'h84, 8'h80);
    rx_rd = 1; cyc(); idle();
    expect_now("R5", 8'h04, 8'h04);
    rx_rd = 1; cyc(); idle();
    expect_now("R7", 8'h80, 8'h80);
    lsr_rd = 1; cyc(); idle();
    expect_now("R7", 8'h84, 8'h00);

    // R8 set wins over clear
    lsr_rd = 1; rx_push = 1; rx_fe = 1; cyc(); idle();
    expect_now("R8", 8'h08, 8'h08);
    lsr_rd = 1; cyc(); idle();
    expect_now("R7", 8'h88, 8'h80);
    rx_rd = 1; cyc(); lsr_rd = 1; rx_rd = 0; cyc(); idle();
    expect_now("R7", 8'h80, 8'h00);

    // R7 bit 7 silent in single-character mode
    fifo_mode = 0;
    rx_push = 1; rx_pe = 1; cyc(); idle();
    expect_now("R7", 8'h84, 8'h04);
    rx_rd = 1; lsr_rd = 1; cyc(); idle();
    fifo_mode = 1;

    // R6 break: 8 data bits, no parity -> limit 23
    rx_line = 0;
    for (int i = 0; i < 23; i++) begin bit_tick = 1; cyc(); end
    idle(); rx_push = 1; cyc(); idle();
    expect_now("R6", 8'h10, 8'h00);
    rx_rd = 1; cyc(); idle();
    bit_tick = 1; cyc(); idle();
    rx_line = 1; rx_push = 1; cyc(); idle();
    expect_now("R6", 8'h10, 8'h10);
    rx_rd = 1; lsr_rd = 1; cyc(); idle();
    expect_now("R6", 8'h10, 8'h00);

    // R11 mark restarts the run
    rx_line = 0;
    for (int i = 0; i < 20; i++) begin bit_tick = 1; cyc(); end
    idle(); rx_line = 1; cyc(); rx_line = 0;
    for (int i = 0; i < 20; i++) begin bit_tick = 1; cyc(); end
    idle(); rx_line = 1; rx_push = 1; cyc(); idle();
    expect_now("R11", 8'h10, 8'h00);
    rx_rd = 1; cyc(); idle();

    // R9 / R10 transmit side
    tx_level = 5'd2; thr_wr = 1; cyc(); idle();
    expect_now("R9", 8'h60, 8'h00);
    tx_level = 5'd0;
    expect_now("R10", 8'h60, 8'h00);
    cyc();
    expect_now("R9", 8'h60, 8'h60);
    tx_busy = 1;
    expect_now("R10", 8'h60, 8'h20);
    cyc(); tx_busy = 0;

    // constrained random against the model
    for (int n = 0; n < 2500; n++) begin
      if (n == 1800) fifo_mode = 0;
      rx_push   = ($urandom % 3) == 0;
      rx_pe     = ($urandom % 8) == 0;
      rx_fe     = ($urandom % 8) == 0;
      rx_rd     = ($urandom % 4) == 0;
      lsr_rd    = ($urandom % 6) == 0;
      thr_wr    = ($urandom % 8) == 0;
      tx_level  = 5'($urandom % 3);
      tx_busy   = ($urandom % 4) == 0;
      thre_ie   = ($urandom % 2) == 0;
      bit_tick  = ($urandom % 2) == 0;
      rx_line   = (n % 64) >= 40 ? 1'b0 : (($urandom % 8) != 0);
      parity_en = ($urandom % 16) == 0 ? ~parity_en : parity_en;
      if (($urandom % 50) == 0) trig_sel = 2'($urandom % 4);
      cyc();
    end
    idle(); rx_line = 1;
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule